// File: doc/BRIEF.md
# Scan Data Register Selector

This block sits between a test access port state machine and the data registers it reaches. It decodes the 4-bit instruction held by the TAP and routes the serial path from TDI to TDO through one of four data registers: a one-bit bypass cell, a 32-bit identification register, a boundary chain of configurable length, or a one-bit device-reset cell. The TAP supplies capture, shift and update strobes. Each strobe acts only on the register that the current instruction selects.

The boundary chain samples the parallel pin inputs on capture. On update it copies its contents into a bank of output latches. Those latches are brought out as a parallel port and are never connected to the pads, so preloading values does not disturb the running system. The reset cell drives the device reset request directly, with no update stage. It never clears the TAP logic. A test-logic-reset input clears every register in the block.

Top module: `jtag_dr_select`

## Requirements
- R1: Instruction 0x1 selects the identification register, 0x2 the boundary chain, 0xC the reset cell and 0xF the bypass cell; every other 4-bit code selects the bypass cell.
- R2: With bypass selected, capture loads 0 into the bypass cell, and each shift cycle moves TDI into it, so TDO repeats TDI one cycle later.
- R3: With the identification register selected, capture loads ID_VALUE (bit 0 is 1), and successive shifts present it on TDO least significant bit first.
- R4: With the boundary chain selected, capture samples pin_in into the chain; shift moves TDI into the most significant cell while TDO shows cell 0.
- R5: Update with the boundary chain selected copies the chain into latch_out; latch_out holds its value on every other cycle, including updates under other instructions.
- R6: With the reset cell selected, each shift loads TDI into the cell, and dev_reset_req equals the cell from the next cycle on, with no update stage.
- R7: While tap_reset is high, every register is cleared: dev_reset_req is 0, latch_out is 0 and TDO is 0.
- R8: A register that is not selected keeps its contents across capture, shift and update activity on other instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | Test-logic-reset, active high, asynchronous clear |
| tdi | input | 1 | Serial data in |
| instr | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture strobe for the selected data register |
| shift_dr | input | 1 | Shift strobe for the selected data register |
| update_dr | input | 1 | Update strobe for the selected data register |
| pin_in | input | BSC_LEN | Pin values sampled by the boundary chain |
| latch_out | output | BSC_LEN | Boundary output latches, never connected to the pads |
| tdo | output | 1 | Serial data out, bit 0 of the selected register |
| dev_reset_req | output | 1 | Device reset request, high while the reset cell holds 1 |

## Verification
The assertions check on every cycle that latch_out changes only on a boundary update and then takes the chain value, that the reset request follows the shifted TDI and otherwise holds, that a bypass capture yields a 0 on TDO, that an identification capture loads ID_VALUE, and that everything is clear during tap_reset. Only the bench's scenarios can show the following behaviours: full serial readout of the identification value and of the sampled pins, the fall-back to bypass for undefined codes, and a preloaded chain surviving a stretch of bypass traffic before its update.

// File: rtl/jtag_dr_pkg.sv
package jtag_dr_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_IDENT   = 4'h1;
  localparam logic [IR_W-1:0] OP_PRELOAD = 4'h2;
  localparam logic [IR_W-1:0] OP_DEVRST  = 4'hC;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;

  typedef enum logic [1:0] {
    DR_BYPASS   = 2'd0,
    DR_BOUNDARY = 2'd1,
    DR_IDENT    = 2'd2,
    DR_DEVRST   = 2'd3
  } dr_sel_e;

  // Instruction decode; anything unlisted falls back to the bypass cell.
  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    dr_sel_e r;
    case (op)
      OP_IDENT:   r = DR_IDENT;
      OP_PRELOAD: r = DR_BOUNDARY;
      OP_DEVRST:  r = DR_DEVRST;
      default:    r = DR_BYPASS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/jtag_instr_decode.sv
module jtag_instr_decode
  import jtag_dr_pkg::*;
(
  input  logic [IR_W-1:0] instr,
  output dr_sel_e         sel
);
  always_comb sel = decode_op(instr);
endmodule

// File: rtl/jtag_scan_reg.sv
module jtag_scan_reg #(
  parameter int W = 1
) (
  input  logic         tck,
  input  logic         tap_reset,
  input  logic         sel,
  input  logic         cap_evt,
  input  logic         shift_evt,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);
  // One shift step: every cell takes its upper neighbour, TDI enters at the top.
  function automatic logic [W-1:0] shift_step(input logic [W-1:0] cur, input logic din);
    logic [W-1:0] r;
    for (int i = 0; i < W - 1; i++) r[i] = cur[i+1];
    r[W-1] = din;
    return r;
  endfunction

  always_ff @(posedge tck or posedge tap_reset) begin
    if (tap_reset)            q <= '0;
    else if (sel && cap_evt)  q <= cap_val;
    else if (sel && shift_evt) q <= shift_step(q, tdi);
  end
endmodule

// File: rtl/jtag_out_latch.sv
module jtag_out_latch #(
  parameter int N = 8
) (
  input  logic         tck,
  input  logic         tap_reset,
  input  logic         upd_evt,
  input  logic [N-1:0] chain,
  output logic [N-1:0] q
);
  always_ff @(posedge tck or posedge tap_reset) begin
    if (tap_reset)    q <= '0;
    else if (upd_evt) q <= chain;
  end
endmodule

// File: rtl/jtag_dr_select.sv
module jtag_dr_select
  import jtag_dr_pkg::*;
#(
  parameter int              BSC_LEN  = 8,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4B1D_2E35
) (
  input  logic               tck,
  input  logic               tap_reset,
  input  logic               tdi,
  input  logic [IR_W-1:0]    instr,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic [BSC_LEN-1:0] pin_in,
  output logic [BSC_LEN-1:0] latch_out,
  output logic               tdo,
  output logic               dev_reset_req
);
  dr_sel_e sel;

  // Named events for the checker.
  logic sel_bypass, sel_bsc, sel_ident, sel_devrst;
  logic cap_evt, shift_evt, upd_bsc;

  logic               byp_q;
  logic               rst_q;
  logic [ID_W-1:0]    id_q;
  logic [BSC_LEN-1:0] bsc_q;

  jtag_instr_decode u_dec (.instr(instr), .sel(sel));

  assign sel_bypass = (sel == DR_BYPASS);
  assign sel_bsc    = (sel == DR_BOUNDARY);
  assign sel_ident  = (sel == DR_IDENT);
  assign sel_devrst = (sel == DR_DEVRST);

  assign cap_evt   = capture_dr;
  assign shift_evt = shift_dr & ~capture_dr;
  assign upd_bsc   = update_dr & sel_bsc;

  jtag_scan_reg #(.W(1)) u_bypass (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_bypass),
    .cap_evt(cap_evt), .shift_evt(shift_evt), .tdi(tdi),
    .cap_val(1'b0), .q(byp_q)
  );

  jtag_scan_reg #(.W(ID_W)) u_ident (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_ident),
    .cap_evt(cap_evt), .shift_evt(shift_evt), .tdi(tdi),
    .cap_val(ID_VALUE), .q(id_q)
  );

  jtag_scan_reg #(.W(BSC_LEN)) u_bsc (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_bsc),
    .cap_evt(cap_evt), .shift_evt(shift_evt), .tdi(tdi),
    .cap_val(pin_in), .q(bsc_q)
  );

  // Reset cell: capture reloads its own value, so only shift changes it.
  jtag_scan_reg #(.W(1)) u_devrst (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_devrst),
    .cap_evt(cap_evt), .shift_evt(shift_evt), .tdi(tdi),
    .cap_val(rst_q), .q(rst_q)
  );

  jtag_out_latch #(.N(BSC_LEN)) u_latch (
    .tck(tck), .tap_reset(tap_reset), .upd_evt(upd_bsc),
    .chain(bsc_q), .q(latch_out)
  );

  assign dev_reset_req = rst_q;

  always_comb begin
    case (sel)
      DR_IDENT:    tdo = id_q[0];
      DR_BOUNDARY: tdo = bsc_q[0];
      DR_DEVRST:   tdo = rst_q;
      default:     tdo = byp_q;
    endcase
  end
endmodule

// File: rtl/jtag_dr_select_chk.sv
module jtag_dr_select_chk #(
  parameter int              BSC_LEN  = 8,
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4B1D_2E35
) (
  input logic               tck,
  input logic               tap_reset,
  input logic               tdi,
  input logic               capture_dr,
  input logic               shift_dr,
  input logic               tdo,
  input logic               dev_reset_req,
  input logic [BSC_LEN-1:0] latch_out,
  input logic               sel_bypass,
  input logic               sel_ident,
  input logic               sel_devrst,
  input logic               upd_bsc,
  input logic [ID_W-1:0]    id_q,
  input logic [BSC_LEN-1:0] bsc_q
);
  assert_latch_hold_R5: assert property (@(posedge tck) disable iff (tap_reset)
    !upd_bsc |=> $stable(latch_out));

  assert_latch_copy_R5: assert property (@(posedge tck) disable iff (tap_reset)
    upd_bsc |=> latch_out == $past(bsc_q));

  assert_rst_follow_R6: assert property (@(posedge tck) disable iff (tap_reset)
    (sel_devrst && shift_dr && !capture_dr) |=> dev_reset_req == $past(tdi));

  assert_rst_hold_R8: assert property (@(posedge tck) disable iff (tap_reset)
    !(sel_devrst && shift_dr) |=> $stable(dev_reset_req));

  assert_byp_zero_R2: assert property (@(posedge tck) disable iff (tap_reset)
    (sel_bypass && capture_dr) |=> (!sel_bypass || tdo == 1'b0));

  assert_id_load_R3: assert property (@(posedge tck) disable iff (tap_reset)
    (sel_ident && capture_dr) |=> id_q == ID_VALUE);

  assert_clear_R7: assert property (@(posedge tck)
    tap_reset |-> (!dev_reset_req && latch_out == '0 && !tdo));
endmodule

bind jtag_dr_select jtag_dr_select_chk #(
  .BSC_LEN(BSC_LEN), .ID_W(ID_W), .ID_VALUE(ID_VALUE)
) u_chk (
  .tck(tck), .tap_reset(tap_reset), .tdi(tdi),
  .capture_dr(capture_dr), .shift_dr(shift_dr),
  .tdo(tdo), .dev_reset_req(dev_reset_req), .latch_out(latch_out),
  .sel_bypass(sel_bypass), .sel_ident(sel_ident), .sel_devrst(sel_devrst),
  .upd_bsc(upd_bsc), .id_q(id_q), .bsc_q(bsc_q)
);

// File: tb/tb_jtag_dr_select.sv
module tb_jtag_dr_select;
  localparam int          N   = 8;
  localparam logic [31:0] IDV = 32'h4B1D_2E35;

  logic tck = 1'b0;
  logic tap_reset, tdi, capture_dr, shift_dr, update_dr;
  logic [3:0]   instr;
  logic [N-1:0] pin_in, latch_out;
  logic tdo, dev_reset_req;

  int vectors = 0;
  int fails   = 0;

  always #10 tck = ~tck;

  jtag_dr_select #(.BSC_LEN(N), .ID_W(32), .ID_VALUE(IDV)) dut (
    .tck(tck), .tap_reset(tap_reset), .tdi(tdi), .instr(instr),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .pin_in(pin_in), .latch_out(latch_out), .tdo(tdo), .dev_reset_req(dev_reset_req)
  );

  // Behavioural reference model.
  bit m_byp, m_rst;
  bit m_id[$];
  bit m_bsc[$];
  logic [N-1:0] m_lat;

  function automatic int which(input logic [3:0] op);
    if (op == 4'h1) return 1;
    if (op == 4'h2) return 2;
    if (op == 4'hC) return 3;
    return 0;
  endfunction

  function automatic logic [N-1:0] bsc_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = m_bsc[i];
    return v;
  endfunction

  task automatic model_clear();
    m_byp = 0; m_rst = 0; m_lat = '0;
    m_id.delete(); m_bsc.delete();
    for (int i = 0; i < 32; i++) m_id.push_back(1'b0);
    for (int i = 0; i < N; i++)  m_bsc.push_back(1'b0);
  endtask

  always @(posedge tck or posedge tap_reset) begin
    if (tap_reset) model_clear();
    else begin
      int k;
      logic [N-1:0] old_bsc;
      k = which(instr);
      old_bsc = bsc_vec();
      if (capture_dr) begin
        if (k == 0) m_byp = 0;
        if (k == 1) for (int i = 0; i < 32; i++) m_id[i] = IDV[i];
        if (k == 2) for (int i = 0; i < N; i++)  m_bsc[i] = pin_in[i];
      end else if (shift_dr) begin
        if (k == 0) m_byp = tdi;
        if (k == 1) begin void'(m_id.pop_front());  m_id.push_back(tdi);  end
        if (k == 2) begin void'(m_bsc.pop_front()); m_bsc.push_back(tdi); end
        if (k == 3) m_rst = tdi;
      end
      if (update_dr && k == 2) m_lat = old_bsc;
    end
  end

  function automatic bit model_tdo();
    case (which(instr))
      1: return m_id[0];
      2: return m_bsc[0];
      3: return m_rst;
      default: return m_byp;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "tdo", {31'b0, tdo}, {31'b0, model_tdo()});
    check(tag, "latch_out", {{(32-N){1'b0}}, latch_out}, {{(32-N){1'b0}}, m_lat});
    check(tag, "dev_reset_req", {31'b0, dev_reset_req}, {31'b0, m_rst});
  endtask

  task automatic step(input string tag, input logic c, input logic s, input logic u, input logic d);
    capture_dr = c; shift_dr = s; update_dr = u; tdi = d;
    @(posedge tck);
    @(negedge tck);
    compare(tag);
    capture_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] got;
    tap_reset = 1; tdi = 0; capture_dr = 0; shift_dr = 0; update_dr = 0;
    instr = 4'hF; pin_in = '0;
    repeat (2) @(negedge tck);
    check("R7", "reset tdo", {31'b0, tdo}, 32'd0);
    check("R7", "reset latch", {24'b0, latch_out}, 32'd0);
    check("R7", "reset req", {31'b0, dev_reset_req}, 32'd0);
    tap_reset = 0;

    // R2: bypass delays TDI by one cycle after a zero capture.
    instr = 4'hF;
    step("R2", 1, 0, 0, 0);
    check("R2", "capture zero", {31'b0, tdo}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      step("R2", 0, 1, 0, 1'((8'hB4 >> i) & 1));
      check("R2", "delay", {31'b0, tdo}, {31'b0, 1'((8'hB4 >> i) & 1)});
    end

    // R1: an undefined code behaves as bypass.
    instr = 4'h7;
    step("R1", 1, 0, 0, 0);
    check("R1", "undef capture", {31'b0, tdo}, 32'd0);
    step("R1", 0, 1, 0, 1);
    check("R1", "undef shift", {31'b0, tdo}, 32'd1);

    // R3: read the identification value LSB first.
    instr = 4'h1;
    step("R3", 1, 0, 0, 0);
    for (int i = 0; i < 32; i++) begin
      got[i] = tdo;
      step("R3", 0, 1, 0, 0);
    end
    check("R3", "id readout", got, IDV);

    // R4 / R5: sample pins, shift in new data, update latches.
    instr = 4'h2; pin_in = 8'hA5;
    step("R4", 1, 0, 0, 0);
    pin_in = 8'h00;
    got = '0;
    for (int i = 0; i < N; i++) begin
      got[i] = tdo;
      step("R4", 0, 1, 0, 1'((8'h3C >> i) & 1));
    end
    check("R4", "sampled pins", got, 32'hA5);
    step("R5", 0, 0, 1, 0);
    check("R5", "latch update", {24'b0, latch_out}, 32'h3C);

    // R8: preload 0x81, run bypass traffic with update, then update the chain.
    for (int i = 0; i < N; i++) step("R8", 0, 1, 0, 1'((8'h81 >> i) & 1));
    check("R8", "no update yet", {24'b0, latch_out}, 32'h3C);
    instr = 4'hF;
    step("R5", 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R8", 0, 1, 0, 1);
    step("R5", 0, 0, 1, 0);
    check("R5", "update ignored", {24'b0, latch_out}, 32'h3C);
    instr = 4'h2;
    step("R8", 0, 0, 1, 0);
    check("R8", "chain kept", {24'b0, latch_out}, 32'h81);

    // R6: reset cell drives the request directly.
    instr = 4'hC;
    step("R6", 1, 0, 0, 0);
    check("R6", "capture no change", {31'b0, dev_reset_req}, 32'd0);
    step("R6", 0, 1, 0, 1);
    check("R6", "req set", {31'b0, dev_reset_req}, 32'd1);
    step("R6", 0, 1, 0, 1);
    step("R6", 0, 0, 1, 0);
    check("R6", "req held", {31'b0, dev_reset_req}, 32'd1);
    instr = 4'hF;
    for (int i = 0; i < 3; i++) step("R8", 0, 1, 0, 0);
    check("R8", "req kept", {31'b0, dev_reset_req}, 32'd1);
    instr = 4'hC;
    step("R6", 0, 1, 0, 0);
    check("R6", "req cleared", {31'b0, dev_reset_req}, 32'd0);
    step("R6", 0, 1, 0, 1);

    // R7: test-logic-reset clears everything.
    tap_reset = 1;
    @(posedge tck); @(negedge tck);
    compare("R7");
    check("R7", "clear req", {31'b0, dev_reset_req}, 32'd0);
    check("R7", "clear latch", {24'b0, latch_out}, 32'd0);
    tap_reset = 0;
    step("R7", 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule